// File: doc/BRIEF.md
# Multi-Source Reset Controller with Cause Flags

This block gathers every reset request in a subsystem into a single synchronous system reset, `sys_rst`. Nine causes can raise it. They are power-on, an external reset pin, a software reset strobe, a watchdog timeout, a brown-out detect, three CPU fault flags and a configuration mismatch flag. The external pin is first synchronized and then debounced by a consecutive-sample filter. The brown-out detect passes only while brown-out protection is armed. Arming is chosen by a two-bit mode field, a software enable bit and the sleep state.

Each cause has its own sticky flag in a nine-bit cause register, which software can read and write through a simple port. Power-on clears the register and then sets only the brown-out and power-on flags. Any other cause sets only its own flag and leaves the rest unchanged, so the flags persist across non-power-on resets. Software writes only change the flags and never cause a reset.

A sequencer with three states drives the output:

- **RUN**: the reset is released.
- **HOLD**: at least one request is active.
- **STRETCH**: all requests have gone, and the reset is held for a fixed number of clocks.

The transitions are:

- RUN→HOLD when any request appears.
- HOLD→STRETCH when no request remains.
- STRETCH→HOLD when a request returns.
- STRETCH→RUN when the count expires.
- From any state, power-on forces the sequencer to HOLD.

Top module: `rstctl_top`

## Requirements
- R1: When any qualified request is seen at a clock edge, `sys_rst` is high from that edge on. Power-on behaves the same way.
- R2: After the last request is seen low at an edge, `sys_rst` stays high for exactly 16 more clock cycles and then falls.
- R3: While `por_pulse` is high, the cause register reads 0x003, meaning bit 1 (power-on) and bit 0 (brown-out) are set and all others are clear. `sys_rst` is also high.
- R4: A non-power-on cause sets only its own bit and leaves the other bits unchanged. The bits are: external pin = 2, software = 3, watchdog = 4, trap conflict = 5, illegal opcode = 6, uninitialized register = 7, configuration mismatch = 8, brown-out = 0.
- R5: When `reg_wr` is high at an edge, `reg_wdata` is loaded into the cause register, and `reg_rdata` shows the register at all times. A write never raises `sys_rst`.
- R6: A flag is set on the first cycle its request is seen. If a write lands in the same cycle, the hardware set wins for that bit.
- R7: A flag is set only on a rising request. A request that is held high does not set the flag again after software clears it.
- R8: The external pin passes a two-flop synchronizer. It is accepted only after 4 consecutive high synchronized samples. Pulses of 1 to 3 cycles leave `sys_rst` low and bit 2 clear.
- R9: Brown-out is armed according to `bor_mode`:
  - 00: never armed.
  - 01: armed when `sw_bor_en` is high.
  - 10: armed while `sleep_active` is low.
  - 11: always armed.

  An unarmed brown-out detect neither sets bit 0 nor raises `sys_rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_pulse | input | 1 | Power-on detect, active high |
| ext_rst_pin | input | 1 | External reset pin, active high, asynchronous |
| sw_rst | input | 1 | Software reset strobe |
| wdt_timeout | input | 1 | Watchdog timeout |
| bor_detect | input | 1 | Brown-out detect |
| trap_fault | input | 1 | Trap conflict fault |
| illop_fault | input | 1 | Illegal opcode fault |
| uninit_fault | input | 1 | Uninitialized working register fault |
| cfg_mismatch | input | 1 | Configuration mismatch |
| bor_mode | input | 2 | Brown-out arming mode |
| sw_bor_en | input | 1 | Software brown-out enable |
| sleep_active | input | 1 | Device in sleep |
| reg_wr | input | 1 | Cause register write strobe |
| reg_wdata | input | 9 | Cause register write data |
| reg_rdata | output | 9 | Cause register contents |
| sys_rst | output | 1 | System reset, active high |

## Verification
The checker watches four behaviours on every cycle:

- Direct requests raise `sys_rst` at the next edge.
- The reset level matches a count of quiet cycles since the last request, which covers the 16-cycle stretch.
- Power-on loads 0x003.
- A rising software request sets its flag.

It also checks that `sys_rst` never rises while no request is present, which covers register writes.

Other behaviours can only be shown by the bench's sweeps:

- The debounce threshold, swept over pin pulse widths 1 to 6.
- All sixteen brown-out arming combinations.
- The one-flag-only rule for each source.
- Write-versus-set priority.
- Non-repetition while a request is held.
- Readback of all 512 write patterns.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
    localparam int NUM_FLAGS = 9;

    localparam int F_BOR   = 0;
    localparam int F_POR   = 1;
    localparam int F_EXT   = 2;
    localparam int F_SW    = 3;
    localparam int F_WDT   = 4;
    localparam int F_TRAP  = 5;
    localparam int F_ILLOP = 6;
    localparam int F_UNINT = 7;
    localparam int F_CFG   = 8;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HOLD    = 2'd1,
        ST_STRETCH = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        BORM_OFF    = 2'b00,
        BORM_SOFT   = 2'b01,
        BORM_AWAKE  = 2'b10,
        BORM_ALWAYS = 2'b11
    } bor_mode_t;
endpackage

// File: rtl/rstctl_pin_filter.sv
module rstctl_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILTER_LEN  = 4
) (
    input  logic clk,
    input  logic por,
    input  logic pin_async,
    output logic pin_accepted
);
    localparam int CW = $clog2(FILTER_LEN + 1);
    localparam logic [CW-1:0] CMAX = CW'(FILTER_LEN);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_cnt;

    genvar gi;
    generate
        for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (por) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= pin_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (por) sync_q[gi] <= 1'b0;
                    else     sync_q[gi] <= sync_q[gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (por)                          run_cnt <= '0;
        else if (!sync_q[SYNC_STAGES-1])  run_cnt <= '0;
        else if (run_cnt != CMAX)         run_cnt <= run_cnt + 1'b1;
    end

    assign pin_accepted = (run_cnt == CMAX);
endmodule

// File: rtl/rstctl_bor_gate.sv
module rstctl_bor_gate
    import rstctl_pkg::*;
(
    input  logic       bor_detect,
    input  logic [1:0] bor_mode,
    input  logic       sw_bor_en,
    input  logic       sleep_active,
    output logic       bor_req
);
    logic armed;

    always_comb begin
        unique case (bor_mode_t'(bor_mode))
            BORM_OFF:    armed = 1'b0;
            BORM_SOFT:   armed = sw_bor_en;
            BORM_AWAKE:  armed = !sleep_active;
            BORM_ALWAYS: armed = 1'b1;
            default:     armed = 1'b0;
        endcase
    end

    assign bor_req = armed & bor_detect;
endmodule

// File: rtl/rstctl_status.sv
module rstctl_status
    import rstctl_pkg::*;
#(
    parameter int NF = NUM_FLAGS
) (
    input  logic          clk,
    input  logic          por,
    input  logic [NF-1:0] req,
    input  logic          wr,
    input  logic [NF-1:0] wdata,
    output logic [NF-1:0] flags
);
    logic [NF-1:0] req_q;
    logic [NF-1:0] rise;
    logic [NF-1:0] por_value;
    logic [NF-1:0] base;

    always_comb begin
        por_value        = '0;
        por_value[F_POR] = 1'b1;
        por_value[F_BOR] = 1'b1;
    end

    assign rise = req & ~req_q;
    assign base = wr ? wdata : flags;

    always_ff @(posedge clk) begin
        if (por) begin
            req_q <= '0;
            flags <= por_value;
        end else begin
            req_q <= req;
            flags <= base | rise;
        end
    end
endmodule

// File: rtl/rstctl_seq.sv
module rstctl_seq
    import rstctl_pkg::*;
#(
    parameter int STRETCH_LEN = 16
) (
    input  logic clk,
    input  logic por,
    input  logic any_req,
    output logic sys_rst
);
    localparam int SW = $clog2(STRETCH_LEN + 1);
    localparam logic [SW-1:0] LAST = SW'(STRETCH_LEN - 1);

    seq_state_t state_q, state_d;
    logic [SW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (any_req) state_d = ST_HOLD;
            ST_HOLD:    if (!any_req) state_d = ST_STRETCH;
            ST_STRETCH: begin
                if (any_req)            state_d = ST_HOLD;
                else if (cnt_q == LAST) state_d = ST_RUN;
            end
            default:    state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (por) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_STRETCH && state_d == ST_STRETCH) cnt_q <= cnt_q + 1'b1;
            else                                                cnt_q <= '0;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:     sys_rst = 1'b0;
            ST_HOLD:    sys_rst = 1'b1;
            ST_STRETCH: sys_rst = 1'b1;
            default:    sys_rst = 1'b1;
        endcase
    end
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILTER_LEN  = 4,
    parameter int STRETCH_LEN = 16
) (
    input  logic                 clk,
    input  logic                 por_pulse,
    input  logic                 ext_rst_pin,
    input  logic                 sw_rst,
    input  logic                 wdt_timeout,
    input  logic                 bor_detect,
    input  logic                 trap_fault,
    input  logic                 illop_fault,
    input  logic                 uninit_fault,
    input  logic                 cfg_mismatch,
    input  logic [1:0]           bor_mode,
    input  logic                 sw_bor_en,
    input  logic                 sleep_active,
    input  logic                 reg_wr,
    input  logic [NUM_FLAGS-1:0] reg_wdata,
    output logic [NUM_FLAGS-1:0] reg_rdata,
    output logic                 sys_rst
);
    logic                 ext_ok;
    logic                 bor_req;
    logic [NUM_FLAGS-1:0] req_vec;
    logic                 any_req;

    rstctl_pin_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILTER_LEN (FILTER_LEN)
    ) u_filter (
        .clk         (clk),
        .por         (por_pulse),
        .pin_async   (ext_rst_pin),
        .pin_accepted(ext_ok)
    );

    rstctl_bor_gate u_bor (
        .bor_detect  (bor_detect),
        .bor_mode    (bor_mode),
        .sw_bor_en   (sw_bor_en),
        .sleep_active(sleep_active),
        .bor_req     (bor_req)
    );

    always_comb begin
        req_vec          = '0;
        req_vec[F_BOR]   = bor_req;
        req_vec[F_EXT]   = ext_ok;
        req_vec[F_SW]    = sw_rst;
        req_vec[F_WDT]   = wdt_timeout;
        req_vec[F_TRAP]  = trap_fault;
        req_vec[F_ILLOP] = illop_fault;
        req_vec[F_UNINT] = uninit_fault;
        req_vec[F_CFG]   = cfg_mismatch;
    end

    assign any_req = |req_vec;

    rstctl_status #(.NF(NUM_FLAGS)) u_status (
        .clk  (clk),
        .por  (por_pulse),
        .req  (req_vec),
        .wr   (reg_wr),
        .wdata(reg_wdata),
        .flags(reg_rdata)
    );

    rstctl_seq #(.STRETCH_LEN(STRETCH_LEN)) u_seq (
        .clk    (clk),
        .por    (por_pulse),
        .any_req(any_req),
        .sys_rst(sys_rst)
    );
endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk
    import rstctl_pkg::*;
#(
    parameter int STRETCH_LEN = 16
) (
    input logic                 clk,
    input logic                 por_pulse,
    input logic                 sw_rst,
    input logic                 wdt_timeout,
    input logic                 trap_fault,
    input logic                 cfg_mismatch,
    input logic                 any_req,
    input logic [NUM_FLAGS-1:0] reg_rdata,
    input logic                 sys_rst
);
    localparam int GW = $clog2(STRETCH_LEN + 2);
    localparam logic [GW-1:0] GMAX = GW'(STRETCH_LEN + 1);

    logic          seen_por = 1'b0;
    logic [GW-1:0] gap = '0;

    always_ff @(posedge clk) begin
        if (por_pulse) seen_por <= 1'b1;
        if (por_pulse || any_req) gap <= '0;
        else if (gap != GMAX)     gap <= gap + 1'b1;
    end

    // R1
    direct_req_raises_chk: assert property (@(posedge clk) disable iff (!seen_por || por_pulse)
        (sw_rst || wdt_timeout || trap_fault || cfg_mismatch) |=> sys_rst);

    // R2
    stretch_len_chk: assert property (@(posedge clk) disable iff (!seen_por || por_pulse)
        (gap != '0) |-> (sys_rst == (gap <= GW'(STRETCH_LEN))));

    // R3
    por_load_chk: assert property (@(posedge clk) disable iff (!seen_por)
        por_pulse |=> (reg_rdata == 9'h003 && sys_rst));

    // R5
    no_spurious_rst_chk: assert property (@(posedge clk) disable iff (!seen_por || por_pulse)
        (!sys_rst && !any_req) |=> !sys_rst);

    // R6
    sw_flag_set_chk: assert property (@(posedge clk) disable iff (!seen_por || por_pulse)
        (sw_rst && !$past(sw_rst)) |=> reg_rdata[F_SW]);
endmodule

bind rstctl_top rstctl_chk #(.STRETCH_LEN(STRETCH_LEN)) u_chk (
    .clk         (clk),
    .por_pulse   (por_pulse),
    .sw_rst      (sw_rst),
    .wdt_timeout (wdt_timeout),
    .trap_fault  (trap_fault),
    .cfg_mismatch(cfg_mismatch),
    .any_req     (any_req),
    .reg_rdata   (reg_rdata),
    .sys_rst     (sys_rst)
);

// File: tb/rstctl_top_tb.sv
module rstctl_top_tb;
    logic       clk = 1'b0;
    logic       por_pulse = 1'b0, ext_rst_pin = 1'b0, sw_rst = 1'b0, wdt_timeout = 1'b0;
    logic       bor_detect = 1'b0, trap_fault = 1'b0, illop_fault = 1'b0, uninit_fault = 1'b0;
    logic       cfg_mismatch = 1'b0, sw_bor_en = 1'b0, sleep_active = 1'b0, reg_wr = 1'b0;
    logic [1:0] bor_mode = 2'b00;
    logic [8:0] reg_wdata = '0;
    logic [8:0] reg_rdata;
    logic       sys_rst;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    rstctl_top u_dut (
        .clk(clk), .por_pulse(por_pulse), .ext_rst_pin(ext_rst_pin), .sw_rst(sw_rst),
        .wdt_timeout(wdt_timeout), .bor_detect(bor_detect), .trap_fault(trap_fault),
        .illop_fault(illop_fault), .uninit_fault(uninit_fault), .cfg_mismatch(cfg_mismatch),
        .bor_mode(bor_mode), .sw_bor_en(sw_bor_en), .sleep_active(sleep_active),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_rst(sys_rst)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [8:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 60; i++) begin
            if (!sys_rst) break;
            @(negedge clk);
        end
    endtask

    task automatic set_src(input int idx, input logic v);
        case (idx)
            3: sw_rst       = v;
            4: wdt_timeout  = v;
            5: trap_fault   = v;
            6: illop_fault  = v;
            7: uninit_fault = v;
            8: cfg_mismatch = v;
            default: ;
        endcase
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [8:0] pat;
        int cnt;
        bit saw;
        bit armed;

        // R3: power-on state
        @(negedge clk); por_pulse = 1'b1;
        repeat (3) @(negedge clk);
        check("R3 por flags", reg_rdata, 9'h003);
        check("R3 por rst", sys_rst, 1);
        por_pulse = 1'b0;
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sys_rst) cnt++; else break;
        end
        check("R2 stretch after por", cnt, 16);
        check("R3 flags kept", reg_rdata, 9'h003);

        // R5: exhaustive write/readback, no reset
        for (int v = 0; v < 512; v++) begin
            wr_reg(9'(v));
            check("R5 readback", reg_rdata, v);
            check("R5 no reset", sys_rst, 0);
        end

        // R1 R2 R4: each direct source
        for (int s = 3; s <= 8; s++) begin
            pat = 9'(9'h0A5 ^ (9'h1 << s) ^ 9'(s * 37));
            pat[s] = 1'b0;
            wr_reg(pat);
            @(negedge clk); set_src(s, 1'b1);
            @(negedge clk);
            check("R1 latency", sys_rst, 1);
            check("R4 own flag only", reg_rdata, pat | (9'h1 << s));
            set_src(s, 1'b0);
            cnt = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (sys_rst) cnt++; else break;
            end
            check("R2 stretch", cnt, 16);
        end

        // R6: write and hardware set in the same cycle
        @(negedge clk); reg_wr = 1'b1; reg_wdata = 9'h000; sw_rst = 1'b1;
        @(negedge clk); reg_wr = 1'b0; sw_rst = 1'b0;
        check("R6 hw wins", reg_rdata, 9'h008);
        wait_idle();
        @(negedge clk); reg_wr = 1'b1; reg_wdata = 9'h1F0; wdt_timeout = 1'b1;
        @(negedge clk); reg_wr = 1'b0; wdt_timeout = 1'b0;
        check("R6 hw wins mixed", reg_rdata, 9'h1F0);
        wait_idle();

        // R7: held request does not re-set after clear
        wr_reg(9'h000);
        @(negedge clk); wdt_timeout = 1'b1;
        repeat (3) @(negedge clk);
        wr_reg(9'h000);
        repeat (3) @(negedge clk);
        check("R7 no re-set while held", reg_rdata, 9'h000);
        check("R7 rst held", sys_rst, 1);
        wdt_timeout = 1'b0;
        wait_idle();

        // R8: pin pulse width sweep
        for (int w = 1; w <= 6; w++) begin
            wr_reg(9'h000);
            saw = 0;
            @(negedge clk); ext_rst_pin = 1'b1;
            for (int i = 0; i < w; i++) begin
                @(negedge clk);
                if (sys_rst) saw = 1;
            end
            ext_rst_pin = 1'b0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (sys_rst) saw = 1;
            end
            check("R8 pin flag", reg_rdata[2], (w >= 4) ? 1 : 0);
            check("R8 pin rst", saw, (w >= 4) ? 1 : 0);
            wait_idle();
        end

        // R9: brown-out arming sweep
        for (int m = 0; m < 4; m++) begin
            for (int e = 0; e < 2; e++) begin
                for (int sl = 0; sl < 2; sl++) begin
                    armed = (m == 3) || (m == 1 && e == 1) || (m == 2 && sl == 0);
                    bor_mode = 2'(m); sw_bor_en = e[0]; sleep_active = sl[0];
                    wr_reg(9'h000);
                    @(negedge clk); bor_detect = 1'b1;
                    @(negedge clk);
                    check("R9 bor flag", reg_rdata, armed ? 9'h001 : 9'h000);
                    check("R9 bor rst", sys_rst, armed ? 1 : 0);
                    bor_detect = 1'b0;
                    wait_idle();
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule